// File: doc/BRIEF.md
# Management-Mode RAM Access Guard

This block decides where each physical memory access is routed while a protected region of DRAM is set aside for management-mode code. Two 8-bit control registers, a main register and an extended register, are written through a small configuration port. Each register has its own write mask. For every access the block takes the address and a flag that says whether the CPU is in management mode. From these it names one destination:
- ordinary decode;
- the protected DRAM itself;
- the legacy video/PCI path;
- the remapped high alias of the protected DRAM;
- a blackhole.

Three windows are covered. The first is the 128 KiB legacy window at 0xA0000. The second is a 128 KiB high alias at 0xFEDA0000 that maps the same DRAM. The third is a top segment of low memory that ends at a static top-of-low-memory input. Normal accesses that hit the top segment land in the blackhole: reads return all ones and writes are dropped.

A lock bit in the main register is sticky. Once it is set, the open bit is forced to zero and both registers switch to narrower write masks. Only reset clears the lock. Routing is combinational from the address and the register state. A register write is visible from the following cycle.

Top module: `smram_guard`

## Requirements
- R1: After reset both registers read 0x00. A normal access to 0xA0000 routes to legacy (code 2), and a normal access to 0xFEDA0000 routes to default (code 0). Route codes are: 0 default, 1 protected DRAM, 2 legacy, 3 high alias, 4 blackhole.
- R2: Main register bits are glb_en (bit 0), lock (bit 1) and open (bit 2). Extended register bits are seg_en (bit 0), seg_size (bits 2:1) and hi_en (bit 3). Before lock, only these bits can be written, and the other bits read 0. A write is visible on the outputs after the next clock edge.
- R3: When a main write sets lock, open reads 0 even if the same write set open. While locked, writes change neither register, and only reset clears lock.
- R4: With open=0, a normal access in 0xA0000–0xBFFFF routes to legacy, and a normal access in 0xFEDA0000–0xFEDBFFFF routes to default.
- R5: With open=1 and hi_en=0, a normal access in the low window routes to protected DRAM, and a normal access in the high window routes to default.
- R6: With open=1 and hi_en=1, a normal access in the low window routes to legacy, and a normal access in the high window routes to the high alias.
- R7: A management-mode access with glb_en=1 and hi_en=0 sees protected DRAM in the low window. With glb_en=1 and hi_en=1 it sees the high alias in the high window. Otherwise it follows the normal-access rules in both windows.
- R8: The top segment size is 1 MiB for seg_size 00, 2 MiB for 01 and 8 MiB for 10. It is 0 for seg_size 11 or when seg_en=0.
- R9: The top segment covers addresses from tolm minus the size up to, but not including, tolm. Normal accesses there route to the blackhole, and management-mode accesses route to protected DRAM.
- R10: A blackhole access returns 0xFFFFFFFF on bh_rdata, raises wr_drop on writes and gives the 4-byte-aligned address. When acc_bytes is 1 to 4 it gives bh_be=0xF, meaning the access is handled as a full 32-bit word. Other sizes give bh_be=0.
- R11: Addresses outside all three windows route to default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 main, 1 extended |
| cfg_wdata | input | 8 | Configuration write data |
| main_q | output | 8 | Main control register value |
| ext_q | output | 8 | Extended control register value |
| tolm | input | 32 | Top of low memory, static, 1 MiB aligned |
| acc_addr | input | 32 | Physical address of the access |
| acc_smm | input | 1 | Access is issued in management mode |
| acc_wr | input | 1 | Access is a write |
| acc_bytes | input | 3 | Access size in bytes |
| route | output | 3 | Destination code |
| bh_rdata | output | 32 | Blackhole read data |
| bh_be | output | 4 | Blackhole byte enables |
| bh_dw_addr | output | 32 | Blackhole word-aligned address |
| wr_drop | output | 1 | Write is discarded |

## Verification
The low and high windows are probed under every combination of open and hi_en, once with normal accesses and once with management-mode accesses. Varying glb_en on top of that separates the management override from the normal view of the same window. The top segment is tried with every size encoding, with and without seg_en, and is probed one byte below its base, at its base, at its last byte and at tolm itself, which catches off-by-one and size-decode faults. Lock sequences write open and lock together, then attempt rewrites of both registers, to separate forced clearing of open from masked writes and from stickiness across writes.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int CFG_W  = 8;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  // main register fields
  localparam int M_GLB = 0;
  localparam int M_LCK = 1;
  localparam int M_OPN = 2;
  // extended register fields
  localparam int X_TEN = 0;
  localparam int X_SZL = 1;
  localparam int X_SZH = 2;
  localparam int X_HIE = 3;

  localparam logic [ADDR_W-1:0] LOW_BASE = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] HI_BASE  = 32'hFEDA_0000;
  localparam logic [ADDR_W-1:0] WIN_SPAN = 32'h0002_0000;

  typedef enum logic [2:0] {
    RT_DEFAULT   = 3'd0,
    RT_SMRAM     = 3'd1,
    RT_LEGACY    = 3'd2,
    RT_ALIAS     = 3'd3,
    RT_BLACKHOLE = 3'd4
  } route_e;

  function automatic logic [ADDR_W-1:0] seg_bytes(input logic en, input logic [1:0] code);
    logic [ADDR_W-1:0] r;
    r = '0;
    if (en) begin
      case (code)
        2'b00:   r = 32'h0010_0000;
        2'b01:   r = 32'h0020_0000;
        2'b10:   r = 32'h0080_0000;
        default: r = '0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/smram_cfg_bank.sv
module smram_cfg_bank
  import smram_pkg::*;
#(
  parameter logic [CFG_W-1:0] MAIN_DEF   = 8'h00,
  parameter logic [CFG_W-1:0] MAIN_WMASK = 8'h07,
  parameter logic [CFG_W-1:0] MAIN_LMASK = 8'h00,
  parameter logic [CFG_W-1:0] EXT_DEF    = 8'h00,
  parameter logic [CFG_W-1:0] EXT_WMASK  = 8'h0F,
  parameter logic [CFG_W-1:0] EXT_LMASK  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] main_q,
  output logic [CFG_W-1:0] ext_q
);
  localparam int NREG = 2;
  localparam logic [NREG-1:0][CFG_W-1:0] DEFS   = {EXT_DEF, MAIN_DEF};
  localparam logic [NREG-1:0][CFG_W-1:0] WMASKS = {EXT_WMASK, MAIN_WMASK};
  localparam logic [NREG-1:0][CFG_W-1:0] LMASKS = {EXT_LMASK, MAIN_LMASK};

  logic [CFG_W-1:0] reg_q [NREG];
  logic             locked;

  assign locked = reg_q[0][M_LCK];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam bit IS_MAIN = (g == 0);
    logic [CFG_W-1:0] mask;
    logic [CFG_W-1:0] nxt;
    logic [CFG_W-1:0] q_r;
    logic             upd;

    always_comb begin
      mask = locked ? LMASKS[g] : WMASKS[g];
      upd  = we && (sel == g[0]);
      nxt  = (q_r & ~mask) | (wdata & mask);
      if (IS_MAIN && nxt[M_LCK]) begin
        nxt[M_OPN] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= DEFS[g];
      end else if (upd) begin
        q_r <= nxt;
      end
    end

    assign reg_q[g] = q_r;
  end

  assign main_q = reg_q[0];
  assign ext_q  = reg_q[1];
endmodule

// File: rtl/smram_seg_decode.sv
module smram_seg_decode
  import smram_pkg::*;
(
  input  logic              seg_en,
  input  logic [1:0]        seg_code,
  input  logic [ADDR_W-1:0] tolm,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] size;
  logic [ADDR_W-1:0] base;

  always_comb begin
    size = seg_bytes(seg_en, seg_code);
    base = tolm - size;
    hit  = (size != '0) && (addr >= base) && (addr < tolm);
  end
endmodule

// File: rtl/smram_router.sv
module smram_router
  import smram_pkg::*;
(
  input  logic              smm,
  input  logic [ADDR_W-1:0] addr,
  input  logic              glb_en,
  input  logic              open,
  input  logic              hi_en,
  input  logic              seg_hit,
  output route_e            route
);
  logic in_low;
  logic in_hi;

  always_comb begin
    in_low = (addr >= LOW_BASE) && (addr < LOW_BASE + WIN_SPAN);
    in_hi  = (addr >= HI_BASE)  && (addr < HI_BASE + WIN_SPAN);
    route  = RT_DEFAULT;
    if (in_low) begin
      if (smm && glb_en && !hi_en)  route = RT_SMRAM;
      else if (open && !hi_en)      route = RT_SMRAM;
      else                          route = RT_LEGACY;
    end else if (in_hi) begin
      if (smm && glb_en && hi_en)   route = RT_ALIAS;
      else if (open && hi_en)       route = RT_ALIAS;
      else                          route = RT_DEFAULT;
    end else if (seg_hit) begin
      route = smm ? RT_SMRAM : RT_BLACKHOLE;
    end
  end
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smram_pkg::*;
#(
  parameter logic [7:0] MAIN_DEF   = 8'h00,
  parameter logic [7:0] MAIN_WMASK = 8'h07,
  parameter logic [7:0] MAIN_LMASK = 8'h00,
  parameter logic [7:0] EXT_DEF    = 8'h00,
  parameter logic [7:0] EXT_WMASK  = 8'h0F,
  parameter logic [7:0] EXT_LMASK  = 8'h00,
  parameter int         RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  main_q,
  output logic [7:0]  ext_q,
  input  logic [31:0] tolm,
  input  logic [31:0] acc_addr,
  input  logic        acc_smm,
  input  logic        acc_wr,
  input  logic [2:0]  acc_bytes,
  output logic [2:0]  route,
  output logic [31:0] bh_rdata,
  output logic [3:0]  bh_be,
  output logic [31:0] bh_dw_addr,
  output logic        wr_drop
);
  localparam int BE_W = DATA_W / 8;

  // asynchronous assertion, synchronous release
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic [RST_STAGES-1:0] rst_pipe_d;
  logic                  core_rst_n;

  always_comb rst_pipe_d = {rst_pipe_q[RST_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign core_rst_n = rst_pipe_q[RST_STAGES-1];

  smram_cfg_bank #(
    .MAIN_DEF(MAIN_DEF), .MAIN_WMASK(MAIN_WMASK), .MAIN_LMASK(MAIN_LMASK),
    .EXT_DEF(EXT_DEF),   .EXT_WMASK(EXT_WMASK),   .EXT_LMASK(EXT_LMASK)
  ) u_bank (
    .clk(clk), .rst_n(core_rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .main_q(main_q), .ext_q(ext_q)
  );

  logic seg_hit;

  smram_seg_decode u_seg (
    .seg_en(ext_q[X_TEN]), .seg_code(ext_q[X_SZH:X_SZL]),
    .tolm(tolm), .addr(acc_addr), .hit(seg_hit)
  );

  route_e rt;

  smram_router u_rt (
    .smm(acc_smm), .addr(acc_addr), .glb_en(main_q[M_GLB]),
    .open(main_q[M_OPN]), .hi_en(ext_q[X_HIE]), .seg_hit(seg_hit), .route(rt)
  );

  logic is_bh;
  logic size_ok;

  always_comb begin
    is_bh      = (rt == RT_BLACKHOLE);
    size_ok    = (acc_bytes != 3'd0) && (acc_bytes <= 3'(BE_W));
    route      = rt;
    bh_rdata   = is_bh ? {DATA_W{1'b1}} : '0;
    bh_be      = (is_bh && size_ok) ? {BE_W{1'b1}} : '0;
    bh_dw_addr = is_bh ? {acc_addr[ADDR_W-1:2], 2'b00} : '0;
    wr_drop    = is_bh && acc_wr;
  end
endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk
  import smram_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [7:0]  main_q,
  input logic [7:0]  ext_q,
  input logic        acc_smm,
  input logic [2:0]  route,
  input logic [31:0] bh_rdata,
  input logic [3:0]  bh_be,
  input logic        wr_drop
);
  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    main_q[M_LCK] |=> main_q[M_LCK]);

  assert_lock_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    main_q[M_LCK] |-> !main_q[M_OPN]);

  assert_locked_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    main_q[M_LCK] |=> ($stable(main_q) && $stable(ext_q)));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(main_q) && $stable(ext_q)));

  assert_bh_normal_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_BLACKHOLE) |-> !acc_smm);

  assert_bh_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_BLACKHOLE) |-> (bh_rdata == 32'hFFFF_FFFF));

  assert_no_drop_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (route != RT_BLACKHOLE) |-> (!wr_drop && bh_be == 4'h0));

  assert_normal_dram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_smm && route == RT_SMRAM) |-> (main_q[M_OPN] && !ext_q[X_HIE]));

  assert_normal_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_smm && route == RT_ALIAS) |-> (main_q[M_OPN] && ext_q[X_HIE]));
endmodule

bind smram_guard smram_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .main_q(main_q), .ext_q(ext_q),
  .acc_smm(acc_smm), .route(route), .bh_rdata(bh_rdata), .bh_be(bh_be),
  .wr_drop(wr_drop)
);

// File: tb/sim_smram_guard.sv
module sim_smram_guard;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] TOLM = 32'h7F00_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [7:0]  main_q;
  logic [7:0]  ext_q;
  logic [31:0] tolm;
  logic [31:0] acc_addr;
  logic        acc_smm;
  logic        acc_wr;
  logic [2:0]  acc_bytes;
  logic [2:0]  route;
  logic [31:0] bh_rdata;
  logic [3:0]  bh_be;
  logic [31:0] bh_dw_addr;
  logic        wr_drop;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_guard u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .main_q(main_q), .ext_q(ext_q), .tolm(tolm),
    .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_wr(acc_wr),
    .acc_bytes(acc_bytes), .route(route), .bh_rdata(bh_rdata),
    .bh_be(bh_be), .bh_dw_addr(bh_dw_addr), .wr_drop(wr_drop)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic smm);
    acc_addr = a; acc_smm = smm;
    #1;
  endtask

  task automatic expect_route(input string req, input logic [31:0] a,
                              input logic smm, input logic [2:0] exp);
    probe(a, smm);
    check(req, $sformatf("route @%h smm=%0b", a, smm), 32'(route), 32'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "main after reset", 32'(main_q), 32'h00);
    check("R1", "ext after reset", 32'(ext_q), 32'h00);
    expect_route("R1", 32'h000A_0000, 1'b0, 3'd2);
    expect_route("R1", 32'hFEDA_0000, 1'b0, 3'd0);
  endtask

  task automatic t_masks();
    wr(1'b0, 8'hF5);
    check("R2", "main masked write", 32'(main_q), 32'h05);
    wr(1'b1, 8'hF6);
    check("R2", "ext masked write", 32'(ext_q), 32'h06);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    check("R2", "main cleared", 32'(main_q), 32'h00);
  endtask

  task automatic t_open_modes();
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    expect_route("R4", 32'h000B_FFFF, 1'b0, 3'd2);
    expect_route("R4", 32'hFEDB_FFFF, 1'b0, 3'd0);
    wr(1'b0, 8'h04);
    expect_route("R5", 32'h000A_0000, 1'b0, 3'd1);
    expect_route("R5", 32'hFEDA_0000, 1'b0, 3'd0);
    wr(1'b1, 8'h08);
    expect_route("R6", 32'h000A_0000, 1'b0, 3'd2);
    expect_route("R6", 32'hFEDA_1000, 1'b0, 3'd3);
    wr(1'b0, 8'h00);
    expect_route("R4", 32'hFEDA_1000, 1'b0, 3'd0);
    expect_route("R11", 32'h000C_0000, 1'b0, 3'd0);
    expect_route("R11", 32'h0010_0000, 1'b0, 3'd0);
  endtask

  task automatic t_smm();
    wr(1'b0, 8'h01); wr(1'b1, 8'h00);
    expect_route("R7", 32'h000A_0000, 1'b1, 3'd1);
    expect_route("R7", 32'h000A_0000, 1'b0, 3'd2);
    expect_route("R7", 32'hFEDA_0000, 1'b1, 3'd0);
    wr(1'b1, 8'h08);
    expect_route("R7", 32'hFEDA_0000, 1'b1, 3'd3);
    expect_route("R7", 32'h000A_0000, 1'b1, 3'd2);
    wr(1'b0, 8'h00);
    expect_route("R7", 32'hFEDA_0000, 1'b1, 3'd0);
    wr(1'b1, 8'h00);
    expect_route("R7", 32'h000A_0000, 1'b1, 3'd2);
  endtask

  task automatic t_seg_sizes();
    wr(1'b1, 8'h01);
    expect_route("R9", TOLM - 32'h0010_0000, 1'b0, 3'd4);
    expect_route("R9", TOLM - 32'h0010_0001, 1'b0, 3'd0);
    expect_route("R9", TOLM - 32'd1, 1'b0, 3'd4);
    expect_route("R9", TOLM, 1'b0, 3'd0);
    expect_route("R9", TOLM - 32'h0010_0000, 1'b1, 3'd1);
    wr(1'b1, 8'h03);
    expect_route("R8", TOLM - 32'h0020_0000, 1'b0, 3'd4);
    expect_route("R8", TOLM - 32'h0020_0001, 1'b0, 3'd0);
    wr(1'b1, 8'h05);
    expect_route("R8", TOLM - 32'h0080_0000, 1'b0, 3'd4);
    expect_route("R8", TOLM - 32'h0080_0001, 1'b0, 3'd0);
    wr(1'b1, 8'h07);
    expect_route("R8", TOLM - 32'd1, 1'b0, 3'd0);
    wr(1'b1, 8'h04);
    expect_route("R8", TOLM - 32'd1, 1'b0, 3'd0);
  endtask

  task automatic t_blackhole();
    wr(1'b1, 8'h01);
    acc_wr = 1'b1; acc_bytes = 3'd1;
    probe(32'h7EF0_0007, 1'b0);
    check("R10", "rdata", bh_rdata, 32'hFFFF_FFFF);
    check("R10", "be size1", 32'(bh_be), 32'hF);
    check("R10", "aligned addr", bh_dw_addr, 32'h7EF0_0004);
    check("R10", "wr_drop", 32'(wr_drop), 32'h1);
    acc_bytes = 3'd4; #1;
    check("R10", "be size4", 32'(bh_be), 32'hF);
    acc_bytes = 3'd0; #1;
    check("R10", "be size0", 32'(bh_be), 32'h0);
    acc_bytes = 3'd4;
    probe(32'h7EF0_0007, 1'b1);
    check("R10", "no drop in smm", 32'(wr_drop), 32'h0);
    acc_wr = 1'b0;
    probe(32'h7EF0_0007, 1'b0);
    check("R10", "read no drop", 32'(wr_drop), 32'h0);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_lock();
    wr(1'b0, 8'h06);
    check("R3", "lock clears open", 32'(main_q), 32'h02);
    wr(1'b0, 8'h05);
    check("R3", "main frozen", 32'(main_q), 32'h02);
    wr(1'b1, 8'h08);
    check("R3", "ext frozen", 32'(ext_q), 32'h00);
    expect_route("R3", 32'h000A_0000, 1'b0, 3'd2);
    do_reset();
    check("R3", "reset clears lock", 32'(main_q), 32'h00);
    wr(1'b0, 8'h04);
    check("R3", "writable after reset", 32'(main_q), 32'h04);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    tolm = TOLM; acc_addr = '0; acc_smm = 1'b0; acc_wr = 1'b0; acc_bytes = 3'd4;
    t_reset();
    t_masks();
    t_open_modes();
    t_smm();
    t_seg_sizes();
    t_blackhole();
    t_lock();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule